// File: doc/BRIEF.md
# Raw NAND Flash Page Read Controller

This block reads data out of an 8-bit asynchronous raw NAND flash device. It drives the device's control pins (chip enable, read enable, write enable, command latch, address latch and write protect) and its 8-bit I/O bus. It also watches the device's ready/busy line. The I/O bus is presented as a separate output, output enable and input so that the pad ring can form the tristate.

A host starts a read by presenting a 24-bit block number, an 8-bit offset inside the block and a byte count while `req_ready` is high. The controller then does the following, with no pauses between cycles:
- writes one command byte, then four address bytes;
- waits a fixed settling time, then polls ready/busy;
- streams the requested number of bytes back, each marked by a single-cycle `rd_valid` strobe.

The sequence ends with a one-cycle `rsp_done` pulse. That pulse carries `rsp_err` when the device stayed busy too long.

The state machine moves through these states:
- `S_IDLE` goes to `S_CMD_SU` on an accepted request.
- `S_CMD_SU`, then `S_CMD_WE`, then `S_CMD_HD` make up the command write cycle. From there it goes to `S_ADR_SU`.
- `S_ADR_SU`, then `S_ADR_WE`, then `S_ADR_HD` make up one address cycle. This repeats four times, then it goes to `S_TWB`.
- `S_TWB` holds for the settling delay, then goes to `S_POLL`.
- `S_POLL` goes to `S_RD_LO` when ready is seen. It goes to `S_FIN` with the error flag set when the busy limit expires.
- `S_RD_LO`, then `S_RD_HI` make up one byte. These repeat until the count is exhausted, then it goes to `S_FIN`.
- `S_FIN` goes to `S_IDLE`.

Top module: `nand_rd_ctrl`

## Requirements
- R1: After reset and whenever idle, the block holds these levels: `nand_ce_n`, `nand_we_n` and `nand_re_n` high; `nand_cle`, `nand_ale` and `nand_io_oe` low; `nand_wp_n` low; `req_ready` high.
- R2: Each accepted request produces exactly one write cycle with `nand_cle` high and `nand_ale` low. That cycle carries the byte `READ_CMD` (default 0x00), which the device takes on the rising edge of `nand_we_n`.
- R3: The command is followed by exactly four write cycles with `nand_ale` high and `nand_cle` low. They carry, in this order: block bits 7:0, block bits 15:8, block bits 23:16, then the offset.
- R4: In every write cycle:
  - the byte is driven with `nand_io_oe` high one clock before `nand_we_n` falls;
  - `nand_we_n` stays low for `PULSE_W` clocks;
  - the byte is held one clock after `nand_we_n` rises.
  - Consecutive rising edges of `nand_we_n` are exactly `PULSE_W`+2 clocks apart.
- R5: After the last address byte, the block waits `TWB_CYC` clocks. It does not pull `nand_re_n` low until it has sampled `nand_rb` high through the `SYNC_N`-stage synchronizer.
- R6: For every data byte, `nand_re_n` is low for `PULSE_W` clocks. Between bytes it is high for `PULSE_W` clocks. The byte is sampled one clock before `nand_re_n` rises and appears on `rd_data` with `rd_valid` high for exactly one clock. Bytes arrive in device order.
- R7: A request returns exactly `req_len` bytes; a `req_len` of 0 returns 2^`LEN_W` bytes. `rd_last` is high together with `rd_valid` on the final byte only.
- R8: If `nand_rb` stays low for `BUSY_LIMIT` polled clocks, no read cycle happens. `rsp_done` and `rsp_err` are then both high for one clock. `rsp_err` is low on every other completion.
- R9: `nand_wp_n` is high only while a sequence is in progress. `nand_io_oe` is low whenever `nand_re_n` is low.
- R10: `nand_ce_n` stays low from the command cycle through the `rsp_done` clock, and is high on the clock after `rsp_done`.
- R11: `req_valid` is ignored while a sequence is in progress. Requests that arrive then produce no extra command, address or data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle; request taken when both high |
| req_block | input | 24 | Block number |
| req_offset | input | 8 | Offset within the block |
| req_len | input | LEN_W | Byte count (0 means 2^LEN_W) |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Read data byte |
| rd_last | output | 1 | Final byte of the request |
| rsp_done | output | 1 | One-cycle end-of-sequence pulse |
| rsp_err | output | 1 | Busy timeout, valid with `rsp_done` |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb | input | 1 | Ready (high) / busy (low) |
| nand_io_out | output | 8 | I/O bus drive value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus sampled value |

## Verification
The assertions assume the following about the inputs:
- `PULSE_W` is at least 2.
- The device puts a settled byte on `nand_io_in` while `nand_re_n` is low.
- The device drops `nand_rb` early enough after the final address byte for the settling wait to see busy.

The bench's device model meets these conditions by construction. It drives read data on the first falling clock edge after `nand_re_n` falls, and it lowers ready/busy on the same clock that it latches the fourth address byte. The model's busy times stay either clearly below or clearly above the limit, so a synchronizer delay never makes the outcome depend on a single cycle.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_SU,
        S_CMD_WE,
        S_CMD_HD,
        S_ADR_SU,
        S_ADR_WE,
        S_ADR_HD,
        S_TWB,
        S_POLL,
        S_RD_LO,
        S_RD_HI,
        S_FIN
    } nrd_state_e;

    // Address cycle byte: block number low byte first, offset last.
    function automatic logic [7:0] addr_byte(input logic [23:0] blk,
                                             input logic [7:0]  ofs,
                                             input logic [1:0]  idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = blk[7:0];
            2'd1:    b = blk[15:8];
            2'd2:    b = blk[23:16];
            default: b = ofs;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nand_rd_sync.sv
module nand_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= d;
            end
            assign q = s_q;
        end else begin : g_many
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
            assign q = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/nand_rd_capture.sv
module nand_rd_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         last_in,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         last
);

    logic         valid_q;
    logic         last_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= take;
            if (take) begin
                data_q <= din;
                last_q <= last_in;
            end
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
    assign last  = valid_q & last_q;

    // R6: each byte strobe lasts exactly one clock
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
    import nand_rd_pkg::*;
#(
    parameter int         PULSE_W    = 2,
    parameter int         TWB_CYC    = 4,
    parameter int         BUSY_LIMIT = 64,
    parameter int         LEN_W      = 8,
    parameter int         SYNC_N     = 2,
    parameter logic [7:0] READ_CMD   = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_block,
    input  logic [7:0]       req_offset,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_last,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic             nand_ce_n,
    output logic             nand_re_n,
    output logic             nand_we_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_wp_n,
    input  logic             nand_rb,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in
);

    localparam int CNT_M1  = (PULSE_W > TWB_CYC) ? PULSE_W : TWB_CYC;
    localparam int CNT_MAX = (CNT_M1 > BUSY_LIMIT) ? CNT_M1 : BUSY_LIMIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PW_LAST   = CNT_W'(PULSE_W - 1);
    localparam logic [CNT_W-1:0] PW_SAMP   = CNT_W'(PULSE_W - 2);
    localparam logic [CNT_W-1:0] TWB_LAST  = CNT_W'(TWB_CYC - 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(BUSY_LIMIT - 1);
    localparam logic [LEN_W-1:0] ONE_LEFT  = LEN_W'(1);

    nrd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       idx_q, idx_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic             err_q, err_d;
    logic [23:0]      blk_q;
    logic [7:0]       ofs_q;
    logic             rb_s;
    logic             take;

    nand_rd_sync #(.STAGES(SYNC_N)) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb),
        .q     (rb_s)
    );

    assign take = (state_q == S_RD_LO) && (cnt_q == PW_SAMP);

    nand_rd_capture #(.W(8)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .last_in (rem_q == ONE_LEFT),
        .din     (nand_io_in),
        .valid   (rd_valid),
        .data    (rd_data),
        .last    (rd_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        rem_d   = rem_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = S_CMD_SU;
                    err_d   = 1'b0;
                    rem_d   = req_len;
                end
            end
            S_CMD_SU: begin
                state_d = S_CMD_WE;
                cnt_d   = '0;
            end
            S_CMD_WE: begin
                if (cnt_q == PW_LAST) state_d = S_CMD_HD;
                else                  cnt_d   = cnt_q + 1'b1;
            end
            S_CMD_HD: begin
                state_d = S_ADR_SU;
                idx_d   = 2'd0;
            end
            S_ADR_SU: begin
                state_d = S_ADR_WE;
                cnt_d   = '0;
            end
            S_ADR_WE: begin
                if (cnt_q == PW_LAST) state_d = S_ADR_HD;
                else                  cnt_d   = cnt_q + 1'b1;
            end
            S_ADR_HD: begin
                if (idx_q == 2'd3) begin
                    state_d = S_TWB;
                    cnt_d   = '0;
                end else begin
                    state_d = S_ADR_SU;
                    idx_d   = idx_q + 2'd1;
                end
            end
            S_TWB: begin
                if (cnt_q == TWB_LAST) begin
                    state_d = S_POLL;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_POLL: begin
                if (rb_s) begin
                    state_d = S_RD_LO;
                    cnt_d   = '0;
                end else if (cnt_q == BUSY_LAST) begin
                    state_d = S_FIN;
                    err_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_RD_LO: begin
                if (cnt_q == PW_LAST) begin
                    state_d = S_RD_HI;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_RD_HI: begin
                if (cnt_q == PW_LAST) begin
                    cnt_d = '0;
                    if (rem_q == ONE_LEFT) begin
                        state_d = S_FIN;
                    end else begin
                        state_d = S_RD_LO;
                        rem_d   = rem_q - 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            idx_q   <= 2'd0;
            rem_q   <= '0;
            err_q   <= 1'b0;
            blk_q   <= '0;
            ofs_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            rem_q   <= rem_d;
            err_q   <= err_d;
            if (state_q == S_IDLE && req_valid) begin
                blk_q <= req_block;
                ofs_q <= req_offset;
            end
        end
    end

    // Outputs
    always_comb begin
        nand_ce_n   = 1'b0;
        nand_re_n   = 1'b1;
        nand_we_n   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_wp_n   = 1'b1;
        nand_io_out = 8'h00;
        nand_io_oe  = 1'b0;
        req_ready   = 1'b0;
        rsp_done    = 1'b0;
        rsp_err     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                nand_ce_n = 1'b1;
                nand_wp_n = 1'b0;
                req_ready = 1'b1;
            end
            S_CMD_SU, S_CMD_HD: begin
                nand_cle    = 1'b1;
                nand_io_oe  = 1'b1;
                nand_io_out = READ_CMD;
            end
            S_CMD_WE: begin
                nand_cle    = 1'b1;
                nand_io_oe  = 1'b1;
                nand_io_out = READ_CMD;
                nand_we_n   = 1'b0;
            end
            S_ADR_SU, S_ADR_HD: begin
                nand_ale    = 1'b1;
                nand_io_oe  = 1'b1;
                nand_io_out = addr_byte(blk_q, ofs_q, idx_q);
            end
            S_ADR_WE: begin
                nand_ale    = 1'b1;
                nand_io_oe  = 1'b1;
                nand_io_out = addr_byte(blk_q, ofs_q, idx_q);
                nand_we_n   = 1'b0;
            end
            S_TWB, S_POLL, S_RD_HI: begin
            end
            S_RD_LO: nand_re_n = 1'b0;
            S_FIN: begin
                rsp_done = 1'b1;
                rsp_err  = err_q;
            end
            default: begin
                nand_ce_n = 1'b1;
                nand_wp_n = 1'b0;
            end
        endcase
    end

    // R4: write enable low pulse lasts at least two clocks
    a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n);

    // R4: byte still driven and unchanged when write enable rises
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (nand_io_oe && $stable(nand_io_out)));

    // R5: first read pulse only after ready was sampled
    a_r5_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_LO && $past(state_q) == S_POLL) |-> $past(rb_s));

    // R8: an error completion follows a busy poll
    a_r8_err_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($past(state_q) == S_POLL && !$past(rb_s)));

    // R9: bus released and write protect open during read pulses
    a_r9_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (!nand_io_oe && nand_wp_n && !nand_ce_n));

    // R10: chip enable released on the clock after completion
    a_r10_ce_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> nand_ce_n);

    // R11: a request during a sequence never starts a new command
    a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && req_valid) |=> (state_q != S_CMD_SU));

endmodule

// File: tb/nand_rd_ctrl_tb.sv
`timescale 1ns/1ps
module nand_rd_ctrl_tb;

    localparam int         PW   = 2;
    localparam int         TWB  = 4;
    localparam int         LIM  = 64;
    localparam int         LW   = 8;
    localparam logic [7:0] CMD  = 8'h00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_block = '0;
    logic [7:0]    req_offset = '0;
    logic [LW-1:0] req_len = '0;
    logic          rd_valid, rd_last, rsp_done, rsp_err;
    logic [7:0]    rd_data;
    logic          nand_ce_n, nand_re_n, nand_we_n, nand_cle, nand_ale, nand_wp_n;
    logic          nand_rb = 1'b1;
    logic [7:0]    nand_io_out;
    logic          nand_io_oe;
    logic [7:0]    nand_io_in = 8'h00;

    always #2.5 clk = ~clk;

    nand_rd_ctrl #(.PULSE_W(PW), .TWB_CYC(TWB), .BUSY_LIMIT(LIM), .LEN_W(LW),
                   .SYNC_N(2), .READ_CMD(CMD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .req_offset(req_offset), .req_len(req_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rsp_done(rsp_done), .rsp_err(rsp_err),
        .nand_ce_n(nand_ce_n), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_wp_n(nand_wp_n),
        .nand_rb(nand_rb), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wd = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic [7:0] a0, input logic [7:0] a1,
                                            input logic [7:0] a2, input logic [7:0] a3,
                                            input int i);
        logic [7:0] ib;
        ib = i[7:0];
        return a0 ^ {a1[3:0], a1[7:4]} ^ (a2 + 8'h5A) ^ (a3 + ib);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) wd = 1'b1;
    end

    // ---------------- device model ----------------
    logic [7:0] dev_a [4];
    int   dev_an = 0;
    int   busy_len = 0;
    int   busy_left = 0;
    int   rd_idx = 0;
    int   we_rises = 0;
    int   cmd_cnt = 0;
    int   we_low_len = 0, re_low_len = 0, re_high_len = 0, since_rise = 0;
    bit   first_re = 1'b1;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;
    logic [7:0] prev_io = 8'h00;

    always @(negedge clk) begin : dev_model
        bit set_now;
        set_now = 1'b0;
        if (!rst_n) begin
            nand_rb = 1'b1;
            prev_we = 1'b1;
            prev_re = 1'b1;
        end else begin
            // write cycles
            if (prev_we && !nand_we_n) begin
                chk(prev_oe && prev_io == nand_io_out, "R4 setup one clock before we_n fall",
                    int'(prev_io), int'(nand_io_out));
                we_low_len = 1;
            end else if (!nand_we_n) begin
                we_low_len++;
            end
            if (!prev_we && nand_we_n) begin
                chk(we_low_len == PW, "R4 we_n low width", we_low_len, PW);
                if (dev_an < 4 && dev_an > 0 || (cmd_cnt > 0 && dev_an == 0 && since_rise < 100))
                    chk(since_rise == PW + 2, "R4 gap between write cycles", since_rise, PW + 2);
                chk(nand_io_oe && nand_io_out == prev_io, "R4 hold after we_n rise",
                    int'(nand_io_out), int'(prev_io));
                since_rise = 1;
                we_rises++;
                if (nand_cle && !nand_ale) begin
                    chk(nand_io_out == CMD, "R2 command byte", int'(nand_io_out), int'(CMD));
                    cmd_cnt++;
                    dev_an = 0;
                end else if (nand_ale && !nand_cle) begin
                    if (dev_an < 4) dev_a[dev_an] = nand_io_out;
                    dev_an++;
                    if (dev_an == 4) begin
                        nand_rb   = 1'b0;
                        busy_left = busy_len;
                        rd_idx    = 0;
                        first_re  = 1'b1;
                        set_now   = 1'b1;
                    end
                end else begin
                    chk(1'b0, "R2 latch enables on write cycle", {nand_cle, nand_ale}, 2);
                end
            end else if (since_rise < 1000) begin
                since_rise++;
            end
            // busy timer
            if (!set_now && !nand_rb) begin
                if (busy_left > 0) busy_left--;
                else nand_rb = 1'b1;
            end
            // read cycles
            if (prev_re && !nand_re_n) begin
                chk(nand_rb, "R5 read pulse only when ready", int'(nand_rb), 1);
                chk(!nand_io_oe && !nand_ce_n && nand_wp_n, "R9 bus off, ce low, wp high in read",
                    {nand_io_oe, nand_ce_n, nand_wp_n}, 1);
                if (!first_re) chk(re_high_len == PW, "R6 re_n high width", re_high_len, PW);
                first_re = 1'b0;
                re_low_len = 1;
            end else if (!nand_re_n) begin
                re_low_len++;
            end
            if (!prev_re && nand_re_n) begin
                chk(re_low_len == PW, "R6 re_n low width", re_low_len, PW);
                rd_idx++;
                re_high_len = 1;
            end else if (nand_re_n) begin
                re_high_len++;
            end
            nand_io_in = !nand_re_n ? dev_byte(dev_a[0], dev_a[1], dev_a[2], dev_a[3], rd_idx)
                                    : 8'h00;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
            prev_oe = nand_io_oe;
            prev_io = nand_io_out;
        end
    end

    // ---------------- scoreboard ----------------
    logic [8:0] exp_q [$];

    always @(negedge clk) begin : monitor
        logic [8:0] e;
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected extra byte", int'(rd_data), 0);
            end else begin
                e = exp_q.pop_front();
                chk(rd_data == e[7:0], "R6 data byte", int'(rd_data), int'(e[7:0]));
                chk(rd_last == e[8], "R7 last flag", int'(rd_last), int'(e[8]));
            end
        end
    end

    task automatic run_req(input logic [23:0] blk, input logic [7:0] off,
                           input logic [LW-1:0] len, input int busy,
                           input bit exp_err, input bit junk);
        int nbytes;
        int we0;
        int cmd0;
        nbytes = (len == 0) ? (1 << LW) : int'(len);
        we0  = we_rises;
        cmd0 = cmd_cnt;
        busy_len = busy;
        if (!exp_err)
            for (int i = 0; i < nbytes; i++)
                exp_q.push_back({(i == nbytes - 1),
                                 dev_byte(blk[7:0], blk[15:8], blk[23:16], off, i)});
        @(negedge clk);
        while (!req_ready && !wd) @(negedge clk);
        req_valid  = 1'b1;
        req_block  = blk;
        req_offset = off;
        req_len    = len;
        @(negedge clk);
        chk(!req_ready, "R11 request taken, ready dropped", int'(req_ready), 0);
        if (junk) begin
            req_block  = ~blk;
            req_offset = ~off;
            req_len    = 3;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_done && !wd) @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_err == exp_err, "R8 error flag at completion", int'(rsp_err), int'(exp_err));
        chk(!nand_ce_n, "R10 ce_n low during done", int'(nand_ce_n), 0);
        chk(we_rises - we0 == 5, "R3 five write cycles per request", we_rises - we0, 5);
        chk(cmd_cnt - cmd0 == 1, "R2 one command cycle (R11 no extra)", cmd_cnt - cmd0, 1);
        chk({dev_a[0], dev_a[1], dev_a[2], dev_a[3]} == {blk[7:0], blk[15:8], blk[23:16], off},
            "R3 address byte order", int'({dev_a[0], dev_a[1], dev_a[2], dev_a[3]}),
            int'({blk[7:0], blk[15:8], blk[23:16], off}));
        chk(exp_q.size() == 0, "R7 byte count", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        chk(nand_ce_n && !nand_wp_n && req_ready && !rsp_done,
            "R10 ce_n released, R9 wp_n low when idle",
            {nand_ce_n, nand_wp_n, req_ready, rsp_done}, 4'b1010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R1 control pins in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
        chk(!nand_wp_n && !nand_io_oe && req_ready && !rd_valid && !rsp_done,
            "R1 wp_n, oe, ready in reset", {nand_wp_n, nand_io_oe, req_ready, rd_valid, rsp_done}, 5'b00100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(nand_ce_n && !nand_wp_n && req_ready, "R1 idle after reset",
            {nand_ce_n, nand_wp_n, req_ready}, 3'b101);

        run_req(24'h123456, 8'h10, 8'd4,  10,  1'b0, 1'b0);  // R6 R7 main pattern
        run_req(24'hABCDEF, 8'hFF, 8'd1,  0,   1'b0, 1'b0);  // R7 single byte
        run_req(24'h00FF01, 8'h00, 8'd0,  3,   1'b0, 1'b0);  // R7 zero length = 256
        run_req(24'h5A5A5A, 8'h33, 8'd3,  40,  1'b0, 1'b0);  // R5 long busy, no timeout
        run_req(24'h777777, 8'h01, 8'd2,  500, 1'b1, 1'b0);  // R8 timeout
        run_req(24'h010203, 8'hC4, 8'd5,  6,   1'b0, 1'b1);  // R11 junk requests held

        if (wd) chk(1'b0, "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (wd);
        repeat (5) @(negedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule